// File: doc/BRIEF.md
# Programmable Frame Pulse and Clock Generator

This block takes one fast master clock and produces a set of output clocks, each optionally paired with an 8 kHz frame pulse. A single frame counter runs over the whole 125 µs frame, so all channels share one output frame boundary. The boundary is the master-clock edge on which the counter wraps to zero. Every output clock is a power-of-two division of the master clock and is phased so that it has an edge exactly at that boundary. The frame pulse of a channel lasts one period of that channel's clock.

Each channel has its own settings: a rate select, clock polarity, frame pulse level, frame pulse placement and separate drive enables for its clock and its pulse. By default the outputs follow the serial-bus convention in which a falling clock edge at the boundary meets a low pulse. Setting the inversion, level and placement bits gives the other convention, in which a rising clock edge meets a high pulse. Settings are read in the last master cycle of a frame and take effect from the boundary, so a change never shortens or splits a pulse or a clock half-period. Channels built without a frame pulse give only a clock that is aligned to the same boundary.

Top module: `fpgen_top`

## Requirements
- R1: The frame lasts FRAME_CYC master cycles and the boundary is the counter wrap. All outputs repeat with that period while the settings do not change.
- R2: The channel clock period is P = 2^(4-rate) master cycles, where rate is the channel's 2-bit field (0 gives /16, 1 gives /8, 2 gives /4, 3 gives /2), with a 50 % duty cycle.
- R3: When ck_inv is 0, the clock is low during the first P/2 cycles after the boundary, so it falls at the boundary. When ck_inv is 1, the clock is inverted and rises at the boundary.
- R4: When fp_high is 0, the frame pulse is active low and idles high. When fp_high is 1, it is active high and idles low.
- R5: When fp_edge is 0, the pulse is active for P cycles centred on the boundary, from P/2 cycles before it until P/2 cycles after it. When fp_edge is 1, the pulse is active for the first P cycles after the boundary.
- R6: Any settings change made during a frame leaves the outputs as they were until the next boundary. Settings are sampled in the last master cycle of the frame.
- R7: During and after reset the settings are ck_inv equal to CKP_RST, an active-low centred pulse, rate equal to RATE_RST and both enables low, and these hold until the first boundary.
- R8: ck_oe_o and fp_oe_o follow ck_en_i and fp_en_i, and they change only at a boundary.
- R9: A channel whose HAS_FP bit is 0 holds fp_o and fp_oe_o at 0 and still drives an aligned clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (32.768 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_inv_i | input | N_OUT | Clock inversion per channel |
| fp_high_i | input | N_OUT | Frame pulse active level per channel (1 = high) |
| fp_edge_i | input | N_OUT | Frame pulse placement (0 = centred, 1 = after boundary) |
| rate_sel_i | input | 2*N_OUT | Rate field per channel, channel i in bits [2i+1:2i] |
| ck_en_i | input | N_OUT | Clock drive enable per channel |
| fp_en_i | input | N_OUT | Frame pulse drive enable per channel |
| ck_o | output | N_OUT | Output clocks |
| fp_o | output | N_OUT | Frame pulses |
| ck_oe_o | output | N_OUT | Clock tristate enables |
| fp_oe_o | output | N_OUT | Frame pulse tristate enables |

## Verification
The assertions assume that reset is held low long enough for the frame counter to start from zero, and that the settings inputs are stable around the master edge on which they are sampled. The bench changes settings only on falling master edges, at a mid-frame point, so every change lands between two boundaries and stays still across the sampling edge. It sweeps all 32 combinations of rate, inversion, level and placement across the channels, with a different combination on each channel, and checks every master cycle against arithmetic expectations.

// File: rtl/fpgen_pkg.sv
package fpgen_pkg;
   localparam int RATES = 4;
   localparam int SEL_W = 2;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             ck_inv;
      logic             fp_high;
      logic             fp_edge;
      logic             ck_en;
      logic             fp_en;
   } chan_cfg_t;
endpackage

// File: rtl/fpgen_frame_cnt.sv
module fpgen_frame_cnt
   import fpgen_pkg::*;
#(
   parameter int FRAME_CYC = 4096,
   parameter int CNT_W     = $clog2(FRAME_CYC)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             wrap_o
);
   localparam int MAX_PER = 1 << RATES;

   if ((FRAME_CYC % MAX_PER) != 0 || FRAME_CYC < 2 * MAX_PER) begin : g_bad_frame
      $error("frame length must be a multiple of the slowest clock period");
   end

   assign wrap_o    = (cnt_o == CNT_W'(FRAME_CYC - 1));
   assign cnt_nxt_o = wrap_o ? '0 : cnt_o + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_nxt_o;
   end
endmodule

// File: rtl/fpgen_chan.sv
module fpgen_chan
   import fpgen_pkg::*;
#(
   parameter int FRAME_CYC = 4096,
   parameter int CNT_W     = 12,
   parameter bit HAS_FP    = 1'b1,
   parameter bit CKP_RST   = 1'b0,
   parameter int RATE_RST  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  chan_cfg_t        cfg_i,
   output logic             ck_o,
   output logic             fp_o,
   output logic             ck_oe_o,
   output logic             fp_oe_o
);
   localparam chan_cfg_t CFG_RST = '{sel: SEL_W'(RATE_RST), ck_inv: CKP_RST,
                                    fp_high: 1'b0, fp_edge: 1'b0,
                                    ck_en: 1'b0, fp_en: 1'b0};

   chan_cfg_t cfg_q, cfg_nxt;

   function automatic logic ck_level(input logic [CNT_W-1:0] c, input chan_cfg_t f);
      logic [CNT_W-1:0] sh;
      sh = c >> (RATES - 1 - int'(f.sel));
      return sh[0] ^ f.ck_inv;
   endfunction

   function automatic logic fp_level(input logic [CNT_W-1:0] c, input chan_cfg_t f);
      int   half, ci;
      logic act;
      half = 1 << (RATES - 1 - int'(f.sel));
      ci   = int'(c);
      if (f.fp_edge) act = (ci < 2 * half);
      else           act = (ci >= FRAME_CYC - half) || (ci < half);
      return f.fp_high ? act : ~act;
   endfunction

   assign cfg_nxt = wrap_i ? cfg_i : cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= CFG_RST;
         ck_o    <= CKP_RST;
         ck_oe_o <= 1'b0;
      end else begin
         cfg_q   <= cfg_nxt;
         ck_o    <= ck_level(cnt_nxt_i, cfg_nxt);
         ck_oe_o <= cfg_nxt.ck_en;
      end
   end

   if (HAS_FP) begin : g_fp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fp_o    <= 1'b0;
            fp_oe_o <= 1'b0;
         end else begin
            fp_o    <= fp_level(cnt_nxt_i, cfg_nxt);
            fp_oe_o <= cfg_nxt.fp_en;
         end
      end

      // pulse covers the boundary cycle in both placements
      assert_fp_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_i == '0) |-> (fp_o == cfg_q.fp_high));
   end else begin : g_no_fp
      logic unused_fp_cfg;
      assign unused_fp_cfg = ^{cfg_q.fp_high, cfg_q.fp_edge, cfg_q.fp_en};
      assign fp_o    = 1'b0;
      assign fp_oe_o = 1'b0;
   end

   assert_ck_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_i == '0) |-> (ck_o == cfg_q.ck_inv));

   assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> $stable(cfg_q));

   assert_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> ($stable(ck_oe_o) && $stable(fp_oe_o)));
endmodule

// File: rtl/fpgen_top.sv
module fpgen_top
   import fpgen_pkg::*;
#(
   parameter int               N_OUT     = 3,
   parameter int               FRAME_CYC = 4096,
   parameter logic [N_OUT-1:0] HAS_FP    = 3'b011,
   parameter logic [N_OUT-1:0] CKP_RST   = 3'b010,
   parameter int               RATE_RST  = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_OUT-1:0]       ck_inv_i,
   input  logic [N_OUT-1:0]       fp_high_i,
   input  logic [N_OUT-1:0]       fp_edge_i,
   input  logic [SEL_W*N_OUT-1:0] rate_sel_i,
   input  logic [N_OUT-1:0]       ck_en_i,
   input  logic [N_OUT-1:0]       fp_en_i,
   output logic [N_OUT-1:0]       ck_o,
   output logic [N_OUT-1:0]       fp_o,
   output logic [N_OUT-1:0]       ck_oe_o,
   output logic [N_OUT-1:0]       fp_oe_o
);
   localparam int CNT_W = $clog2(FRAME_CYC);

   if (N_OUT < 1 || RATE_RST < 0 || RATE_RST >= RATES) begin : g_bad_cfg
      $error("channel count or reset rate out of range");
   end

   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             wrap;

   fpgen_frame_cnt #(.FRAME_CYC(FRAME_CYC), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .wrap_o(wrap)
   );

   for (genvar i = 0; i < N_OUT; i++) begin : g_ch
      chan_cfg_t cfg;
      assign cfg = '{sel: rate_sel_i[SEL_W*i +: SEL_W], ck_inv: ck_inv_i[i],
                     fp_high: fp_high_i[i], fp_edge: fp_edge_i[i],
                     ck_en: ck_en_i[i], fp_en: fp_en_i[i]};

      fpgen_chan #(
         .FRAME_CYC(FRAME_CYC), .CNT_W(CNT_W), .HAS_FP(HAS_FP[i]),
         .CKP_RST(CKP_RST[i]), .RATE_RST(RATE_RST)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .cnt_i(cnt), .cnt_nxt_i(cnt_nxt),
         .cfg_i(cfg), .ck_o(ck_o[i]), .fp_o(fp_o[i]),
         .ck_oe_o(ck_oe_o[i]), .fp_oe_o(fp_oe_o[i])
      );
   end

   assert_frame_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
endmodule

// File: tb/sim_fpgen_top.sv
module sim_fpgen_top;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 3;
   localparam int FR = 64;
   localparam logic [N-1:0] HASFP = 3'b011;
   localparam logic [N-1:0] CKPR  = 3'b010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] ck_inv_i = '0, fp_high_i = '0, fp_edge_i = '0, ck_en_i = '0, fp_en_i = '0;
   logic [2*N-1:0] rate_sel_i = '0;
   logic [N-1:0] ck_o, fp_o, ck_oe_o, fp_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int   cnt_m;
   int   m_sel [N];
   logic m_inv [N], m_hi [N], m_edge [N], m_cen [N], m_fen [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   fpgen_top #(.N_OUT(N), .FRAME_CYC(FR), .HAS_FP(HASFP), .CKP_RST(CKPR), .RATE_RST(0)) u0 (
      .clk(clk), .rst_n(rst_n), .ck_inv_i(ck_inv_i), .fp_high_i(fp_high_i),
      .fp_edge_i(fp_edge_i), .rate_sel_i(rate_sel_i), .ck_en_i(ck_en_i), .fp_en_i(fp_en_i),
      .ck_o(ck_o), .fp_o(fp_o), .ck_oe_o(ck_oe_o), .fp_oe_o(fp_oe_o)
   );

   function automatic logic exp_ck(int c, int sel, logic inv);
      int p = 1 << (4 - sel);
      return logic'((c % p) >= p / 2) ^ inv;
   endfunction

   function automatic logic exp_fp(int c, int sel, logic hi, logic edg);
      int p = 1 << (4 - sel);
      logic act;
      act = edg ? (c < p) : (((c + p / 2) % FR) < p);
      return hi ? act : ~act;
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at frame cycle %0d: actual %b expected %b", tag, cnt_m, act, exp);
      end
   endtask

   function automatic bit pending_change(int i);
      return (int'(rate_sel_i[2*i +: 2]) != m_sel[i]) || ck_inv_i[i] != m_inv[i] ||
             fp_high_i[i] != m_hi[i] || fp_edge_i[i] != m_edge[i] ||
             ck_en_i[i] != m_cen[i] || fp_en_i[i] != m_fen[i];
   endfunction

   task automatic check_all(bit at_reset);
      for (int i = 0; i < N; i++) begin
         string t;
         logic  efp;
         if (at_reset)               t = "R7";
         else if (pending_change(i)) t = "R6";
         else if (cnt_m == 0)        t = "R1";
         else                        t = "R2/R3";
         chk(t, ck_o[i], exp_ck(cnt_m, m_sel[i], m_inv[i]));
         efp = HASFP[i] ? exp_fp(cnt_m, m_sel[i], m_hi[i], m_edge[i]) : 1'b0;
         chk(HASFP[i] ? (at_reset ? "R7" : "R4/R5") : "R9", fp_o[i], efp);
         chk(at_reset ? "R7" : "R8", ck_oe_o[i], m_cen[i]);
         chk(HASFP[i] ? "R8" : "R9", fp_oe_o[i], HASFP[i] ? m_fen[i] : 1'b0);
      end
   endtask

   task automatic drive_combo(int k);
      for (int i = 0; i < N; i++) begin
         logic [4:0] v;
         v = 5'((k + 5 * i) % 32);
         rate_sel_i[2*i +: 2] = v[1:0];
         ck_inv_i[i]  = v[2];
         fp_high_i[i] = v[3];
         fp_edge_i[i] = v[4];
         ck_en_i[i]   = v[0] ^ v[3];
         fp_en_i[i]   = v[1] ^ v[2];
      end
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_sel[i] = 0; m_inv[i] = CKPR[i]; m_hi[i] = 1'b0; m_edge[i] = 1'b0;
         m_cen[i] = 1'b0; m_fen[i] = 1'b0;
      end
      cnt_m = 0;
      // R7: outputs under reset, with non-default inputs that must not matter
      ck_inv_i = '1; fp_high_i = '1; ck_en_i = '1; fp_en_i = '1;
      repeat (3) @(negedge clk);
      check_all(1'b1);
      ck_inv_i = '0; fp_high_i = '0; ck_en_i = '0; fp_en_i = '0;
      ck_inv_i = CKPR;
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 34 * FR; cyc++) begin
         @(posedge clk);
         if (cnt_m == FR - 1) begin
            cnt_m = 0;
            for (int i = 0; i < N; i++) begin
               m_sel[i] = int'(rate_sel_i[2*i +: 2]); m_inv[i] = ck_inv_i[i];
               m_hi[i] = fp_high_i[i]; m_edge[i] = fp_edge_i[i];
               m_cen[i] = ck_en_i[i]; m_fen[i] = fp_en_i[i];
            end
         end else begin
            cnt_m++;
         end
         @(negedge clk);
         check_all(cyc < FR - 1);
         // R6: new settings are applied mid-frame and must wait for the boundary
         if (cnt_m == 20) drive_combo(cyc / FR);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule